// File: doc/BRIEF.md
# Adaptive-Weight 3x3 Denoising Filter

This block smooths noise in 8-bit grayscale video while keeping edges sharp. It works on one 3x3 window of pixels at a time and produces the filtered value of the centre pixel. For each of the nine positions it measures the absolute intensity gap to the centre and turns that gap into a weight that drops steeply as the gap widens. The weight is the complement of the gap raised to the eighth power, in truncated byte arithmetic. The result is the weighted mean of the window. Neighbours on the far side of an edge get almost no weight, so the edge is not blurred.

The kernel is a fully pipelined datapath that accepts one window per clock. The upstream source assembles the window from a raster stream. The kernel carries a valid/ready handshake on both sides. When the consumer lowers `out_ready` while an output is waiting, the whole pipeline freezes in place. The input side then deasserts `in_ready` in the same cycle, so nothing is dropped or duplicated. An empty output stage never blocks, so the pipeline keeps filling until a result reaches the output.

Top module: `edge_wt_denoise`

## Requirements
- R1: For each position k (0..8) the gap is d = |p_k - p_centre|. The weight starts from w = 255 - d and is squared three times. Each squaring keeps only the upper byte of the 16-bit product (w <- (w*w)>>8). As a result, a neighbour whose gap is 255 gets weight 0 and contributes nothing.
- R2: The output pixel is floor(256 * N / D), limited to 255. N is the sum over positions of (c_k*p_k)>>8 and D is the sum of the weights c_k. Both sums are held in 12 bits.
- R3: While `out_ready` stays high, a window accepted on clock edge t appears on `out_pix` with `out_valid` high right after edge t+10, which is 11 cycles of latency. A new window is accepted on every clock.
- R4: `in_ready` equals `out_ready OR NOT out_valid`. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_pix` keep their values.
- R5: Results leave in the order the windows were accepted. No window is lost or duplicated across any pattern of stalls.
- R6: A synchronous active-high `rst` clears all in-flight valid flags. `out_valid` is low during reset and stays low until a window has been accepted.
- R7: The centre position always gets weight 248, since its gap is 0 and the chain gives 255, 254, 252, 248. The weight sum is therefore at least 248 and never zero.
- R8: A cycle with `in_valid` low produces no output. Such cycles do not disturb the windows around them.
- R9: Window encoding: `in_win[8k+7:8k]` holds pixel k+1 of the window in row-major order. The centre pixel is at bits [39:32].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A window is offered on `in_win` |
| in_ready | output | 1 | The kernel takes the window on this edge |
| in_win | input | 72 | Nine 8-bit pixels, row-major, pixel k+1 at bits [8k+7:8k] |
| out_valid | output | 1 | `out_pix` holds a result |
| out_ready | input | 1 | The consumer takes the result on this edge |
| out_pix | output | 8 | Filtered centre pixel |

## Verification
Flat windows at several levels expose the downward bias that the byte truncation adds. Windows of all zeros and all 255 test both ends of the scale. A window whose centre is at one extreme and whose neighbours are all at the other can only give the right answer if a 255 gap forces a weight of exactly zero. Step edges and isolated impulses check that a neighbour's weight falls off with its gap rather than with its position. Random windows fed back to back with the consumer always ready pin down the 11-cycle latency and the throughput of one window per clock. Random windows under random input gaps and random output stalls test ordering, holding and the ready rule.

// File: rtl/ewd_pkg.sv
package ewd_pkg;
  localparam int PIX_W    = 8;
  localparam int WIN_N    = 9;
  localparam int CTR_IX   = WIN_N / 2;
  localparam int SQ_STEPS = 3;
  localparam int GRP_N    = 3;
  localparam int GRP_SZ   = WIN_N / GRP_N;
  localparam int GRP_W    = PIX_W + $clog2(GRP_SZ);
  localparam int SUM_W    = PIX_W + $clog2(WIN_N);
  localparam int QUO_W    = SUM_W + PIX_W;
  localparam int LANE_LAT = SQ_STEPS + 4;
  localparam int PIPE_LAT = LANE_LAT + 4;

  typedef logic [PIX_W-1:0]   pix_t;
  typedef logic [2*PIX_W-1:0] wide_t;

  localparam pix_t PIX_MAX = '1;

  // product of two pixels, keeping only the upper byte
  function automatic pix_t hi_mul(input pix_t a, input pix_t b);
    wide_t pr;
    pr = wide_t'(a) * wide_t'(b);
    return pr[2*PIX_W-1:PIX_W];
  endfunction

  // weight that a zero gap ends up with after the squaring chain
  function automatic pix_t ctr_weight();
    pix_t x;
    x = PIX_MAX;
    for (int k = 0; k < SQ_STEPS; k++) x = hi_mul(x, x);
    return x;
  endfunction

  localparam pix_t CTR_WT = ctr_weight();
endpackage

// File: rtl/ewd_lane.sv
// One window position: gap, complement, squaring chain, weighted pixel.
module ewd_lane
  import ewd_pkg::*;
(
  input  logic clk,
  input  logic adv,
  input  pix_t pix_i,
  input  pix_t ctr_i,
  output pix_t wt_o,
  output pix_t prod_o
);
  logic [PIX_W:0] dif_q;
  pix_t           dist_q;
  pix_t           dist_c;
  pix_t           sq_q [SQ_STEPS+1];
  pix_t           pd_q [SQ_STEPS+3];

  // magnitude of the two's complement gap (never -256)
  always_comb begin
    if (dif_q[PIX_W]) dist_c = (~dif_q[PIX_W-1:0]) + pix_t'(1);
    else              dist_c = dif_q[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      dif_q    <= {1'b0, pix_i} - {1'b0, ctr_i};
      pd_q[0]  <= pix_i;
      dist_q   <= dist_c;
      pd_q[1]  <= pd_q[0];
      sq_q[0]  <= PIX_MAX - dist_q;
      pd_q[2]  <= pd_q[1];
      for (int k = 0; k < SQ_STEPS; k++) begin
        sq_q[k+1] <= hi_mul(sq_q[k], sq_q[k]);
        pd_q[k+3] <= pd_q[k+2];
      end
      wt_o   <= sq_q[SQ_STEPS];
      prod_o <= hi_mul(sq_q[SQ_STEPS], pd_q[SQ_STEPS+2]);
    end
  end
endmodule

// File: rtl/ewd_sum.sv
// Two-level adder tree for weights and weighted pixels.
module ewd_sum
  import ewd_pkg::*;
(
  input  logic                   clk,
  input  logic                   adv,
  input  pix_t [WIN_N-1:0]       wt_i,
  input  pix_t [WIN_N-1:0]       prod_i,
  output logic [SUM_W-1:0]       den_o,
  output logic [SUM_W-1:0]       num_o
);
  logic [GRP_W-1:0] gden_c [GRP_N];
  logic [GRP_W-1:0] gnum_c [GRP_N];
  logic [GRP_W-1:0] gden_q [GRP_N];
  logic [GRP_W-1:0] gnum_q [GRP_N];
  logic [SUM_W-1:0] tden_c;
  logic [SUM_W-1:0] tnum_c;

  always_comb begin
    for (int g = 0; g < GRP_N; g++) begin
      gden_c[g] = '0;
      gnum_c[g] = '0;
      for (int j = 0; j < GRP_SZ; j++) begin
        gden_c[g] = gden_c[g] + GRP_W'(wt_i[g*GRP_SZ+j]);
        gnum_c[g] = gnum_c[g] + GRP_W'(prod_i[g*GRP_SZ+j]);
      end
    end
  end

  always_comb begin
    tden_c = '0;
    tnum_c = '0;
    for (int g = 0; g < GRP_N; g++) begin
      tden_c = tden_c + SUM_W'(gden_q[g]);
      tnum_c = tnum_c + SUM_W'(gnum_q[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      for (int g = 0; g < GRP_N; g++) begin
        gden_q[g] <= gden_c[g];
        gnum_q[g] <= gnum_c[g];
      end
      den_o <= tden_c;
      num_o <= tnum_c;
    end
  end
endmodule

// File: rtl/ewd_div.sv
// Normalising divide, then clamp to the pixel range.
module ewd_div
  import ewd_pkg::*;
(
  input  logic             clk,
  input  logic             adv,
  input  logic [SUM_W-1:0] num_i,
  input  logic [SUM_W-1:0] den_i,
  output pix_t             pix_o
);
  logic [QUO_W-1:0] quo_c;
  logic [QUO_W-1:0] quo_q;

  // numerator carries back the byte dropped in each weighted product
  always_comb begin
    if (den_i == '0) quo_c = '1;
    else             quo_c = {num_i, {PIX_W{1'b0}}} / QUO_W'(den_i);
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      quo_q <= quo_c;
      pix_o <= (quo_q > QUO_W'(PIX_MAX)) ? PIX_MAX : quo_q[PIX_W-1:0];
    end
  end
endmodule

// File: rtl/edge_wt_denoise.sv
module edge_wt_denoise
  import ewd_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [WIN_N*PIX_W-1:0] in_win,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [PIX_W-1:0]       out_pix
);
  localparam int LANE_IX = LANE_LAT - 1;
  localparam int SUM_IX  = LANE_LAT + 1;

  logic [PIPE_LAT-1:0] vld_q;
  logic                adv;
  pix_t [WIN_N-1:0]    wt_w;
  pix_t [WIN_N-1:0]    pr_w;
  logic [SUM_W-1:0]    den_w;
  logic [SUM_W-1:0]    num_w;

  // whole pipeline moves unless a finished result is waiting
  assign adv       = out_ready | ~vld_q[PIPE_LAT-1];
  assign in_ready  = adv;
  assign out_valid = vld_q[PIPE_LAT-1];

  always_ff @(posedge clk) begin
    if (rst)      vld_q <= '0;
    else if (adv) vld_q <= {vld_q[PIPE_LAT-2:0], in_valid};
  end

  for (genvar i = 0; i < WIN_N; i++) begin : g_lane
    ewd_lane u_lane (
      .clk   (clk),
      .adv   (adv),
      .pix_i (in_win[i*PIX_W +: PIX_W]),
      .ctr_i (in_win[CTR_IX*PIX_W +: PIX_W]),
      .wt_o  (wt_w[i]),
      .prod_o(pr_w[i])
    );
  end

  ewd_sum u_sum (
    .clk   (clk),
    .adv   (adv),
    .wt_i  (wt_w),
    .prod_i(pr_w),
    .den_o (den_w),
    .num_o (num_w)
  );

  ewd_div u_div (
    .clk  (clk),
    .adv  (adv),
    .num_i(num_w),
    .den_i(den_w),
    .pix_o(out_pix)
  );

  // R7
  ctr_weight_chk: assert property (@(posedge clk) disable iff (rst)
    vld_q[LANE_IX] |-> (wt_w[CTR_IX] == CTR_WT));

  // R7
  den_floor_chk: assert property (@(posedge clk) disable iff (rst)
    vld_q[SUM_IX] |-> (den_w >= SUM_W'(CTR_WT)));

  // R2
  num_bound_chk: assert property (@(posedge clk) disable iff (rst)
    vld_q[SUM_IX] |-> (num_w <= den_w));

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));
endmodule

// File: tb/edge_wt_denoise_tb_top.sv
`timescale 1ns/1ps
module edge_wt_denoise_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [71:0] in_win;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  out_pix;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  int exp_q[$];
  int acc_q[$];
  bit lat_chk    = 1'b1;
  bit stall_mode = 1'b0;
  bit prev_stall = 1'b0;
  int prev_pix   = 0;

  edge_wt_denoise dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_win(in_win), .out_valid(out_valid), .out_ready(out_ready),
    .out_pix(out_pix)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  // behavioural model of the filter (R1, R2, R9)
  function automatic int ref_pix(input logic [71:0] w);
    int c, den, num, q;
    c = int'(w[39:32]);
    den = 0;
    num = 0;
    for (int i = 0; i < 9; i++) begin
      int p, d, x;
      p = int'(w[i*8 +: 8]);
      d = (p > c) ? p - c : c - p;
      x = 255 - d;
      for (int k = 0; k < 3; k++) x = (x * x) / 256;
      den += x;
      num += (x * p) / 256;
    end
    q = (num * 256) / den;
    return (q > 255) ? 255 : q;
  endfunction

  // scoreboard, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(in_ready == (out_ready || !out_valid), "R4 ready rule",
          int'(in_ready), int'(out_ready || !out_valid));
      if (prev_stall)
        chk(out_valid && (int'(out_pix) == prev_pix), "R4 hold",
            int'(out_pix), prev_pix);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 spurious output", int'(out_pix), -1);
        end else begin
          int e, a;
          e = exp_q.pop_front();
          a = acc_q.pop_front();
          chk(int'(out_pix) == e, "R2 pixel", int'(out_pix), e);
          if (lat_chk) chk((cyc - a) == 11, "R3 latency", cyc - a, 11);
        end
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(ref_pix(in_win));
        acc_q.push_back(cyc);
      end
      prev_stall = out_valid && !out_ready;
      prev_pix   = int'(out_pix);
    end
  end

  always @(posedge clk) begin
    #1;
    if (stall_mode) out_ready = (($urandom % 3) != 0);
    else            out_ready = 1'b1;
  end

  task automatic send(input logic [71:0] w);
    in_win   = w;
    in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  function automatic logic [71:0] ctr_vs(input int c, input int nb);
    logic [71:0] w;
    for (int i = 0; i < 9; i++) w[i*8 +: 8] = 8'(nb);
    w[39:32] = 8'(c);
    return w;
  endfunction

  function automatic logic [71:0] rows(input int a, input int b, input int c);
    logic [71:0] w;
    for (int i = 0; i < 9; i++) w[i*8 +: 8] = 8'((i < 3) ? a : (i < 6) ? b : c);
    return w;
  endfunction

  function automatic logic [71:0] cols(input int a, input int b);
    logic [71:0] w;
    for (int i = 0; i < 9; i++) w[i*8 +: 8] = 8'(((i % 3) == 0) ? a : b);
    return w;
  endfunction

  function automatic logic [71:0] rnd_win(input int spread);
    logic [71:0] w;
    int base;
    base = int'($urandom % 256);
    for (int i = 0; i < 9; i++) begin
      int v;
      v = (spread >= 256) ? int'($urandom % 256)
                          : base + int'($urandom % (2*spread+1)) - spread;
      v = (v < 0) ? 0 : (v > 255) ? 255 : v;
      w[i*8 +: 8] = 8'(v);
    end
    return w;
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    n_bad++;
    $display("FAIL R5 watchdog act=%0d exp=%0d", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_win = '0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(!out_valid, "R6 in reset", int'(out_valid), 0);
    @(posedge clk); #1; rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_valid, "R6 after reset", int'(out_valid), 0);
    @(posedge clk); #1;

    // directed windows, back to back, consumer always ready
    send(ctr_vs(100, 100));   // R2 flat bias
    send(ctr_vs(0, 0));
    send(ctr_vs(255, 255));
    send(ctr_vs(0, 255));     // R1 far neighbours weigh zero
    send(ctr_vs(255, 0));     // R1, R7
    send(cols(200, 50));      // step edge
    send(rows(30, 30, 220));
    send(ctr_vs(250, 20));    // impulse
    send(ctr_vs(128, 120));
    send(rows(10, 128, 250));
    // R8 gaps between windows
    for (int i = 0; i < 20; i++) begin
      send(rnd_win(256));
      repeat (i % 3) @(posedge clk);
      #1;
    end
    // R3 sustained one-per-clock stream
    for (int i = 0; i < 200; i++) send(rnd_win((i % 2) ? 12 : 256));
    repeat (20) @(posedge clk);
    #1;

    // R5 random stalls and gaps
    lat_chk    = 1'b0;
    stall_mode = 1'b1;
    for (int i = 0; i < 400; i++) begin
      send(rnd_win((i % 3 == 0) ? 6 : 256));
      if (($urandom % 4) == 0) begin
        @(posedge clk);
        #1;
      end
    end
    stall_mode = 1'b0;
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R5 all drained", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule